// File: doc/BRIEF.md
# VCO Calibration Capture Sequencer

This block records the oscillator settings that a synthesizer picks on its own for a single target frequency. On a start command it sends a fixed series of register writes through a separate serial register access engine. These writes route the readback line to the calibration status, select the core and band word for readback, and load the frequency words with automatic calibration turned on. The block then waits until the readback line goes high. After that it switches the readback mode and reads the core and band word. It then moves the read selector to the bias code and reads a second time. The decoded core, band and bias are written into a lookup-table entry. The frequency slot given with the start command picks the entry.

The capture is repeated once per target frequency. Control software can later use the table to program these settings directly and skip calibration. On later runs the block leaves out the write that routes the output multiplexer. It also leaves out a frequency word that has not changed since it was last written. A programmable limit bounds the wait for calibration. When that limit runs out, the run ends with an error flag and the table is left as it was.

Top module: `vco_cal_capture`

## Requirements
- R1: After reset, busy, done, err and acc_req are 0, and every table entry reads back with lut_hit = 0.
- R2: On the first run after reset, the block issues these writes in order. Each word carries its register address in bits 3:0.
  - Register 10 with bits 28:26 = 3'b001.
  - Register 7 with bits 14:12 = 3'b110.
  - Register 4 with bits 29:27 = 3'b111.
  - The frequency word for register 2, unchanged.
  - The frequency word for register 1, unchanged.
  - The register 0 word with bit 21 forced to 1.
  While acc_req is high, the request is held stable until acc_ack.
- R3: After the register 0 write, no access is requested until cal_line has been seen high.
- R4: Once cal_line is high, the block issues four accesses in order:
  - a write of register 7 with bits 14:12 = 3'b111;
  - a read (acc_rd = 1);
  - a write of register 10 with bits 28:26 = 3'b011;
  - a second read.
- R5: The block decodes the two read words as follows:
  - band is bits 7:0 of the first read word;
  - core is bits 10:8 of the first read word, where 3'b001, 3'b010, 3'b011 and 3'b100 stand for cores D, C, B and A;
  - bias is bits 3:0 of the second read word, and its upper bits are ignored.
  The three values appear on cap_core, cap_band and cap_bias. done is high for exactly one cycle.
- R6: A successful run stores core, band and bias in the table entry selected by the slot latched at start. Reading that entry through lut_idx then gives lut_hit = 1 and the stored fields.
- R7: On every run after the first, the register 4 write is left out. The register 2 and register 1 writes are each left out when their word equals the value last written to that register. The other writes keep the order given in R2.
- R8: If cal_line stays low for tmo_lim cycles of waiting, the run ends with done and err both high. No table entry is written. err clears on the next accepted start.
- R9: A start asserted while busy is high has no effect. The running capture continues unchanged, and no entry is written for the slot presented with the ignored start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a capture (accepted when idle) |
| slot_idx | input | IDX_W | Table slot for this capture |
| frq_r0 | input | 32 | Preformatted register 0 word |
| frq_r1 | input | 32 | Preformatted register 1 word |
| frq_r2 | input | 32 | Preformatted register 2 word |
| tmo_lim | input | TMO_W | Calibration wait limit in cycles |
| cal_line | input | 1 | Readback line level |
| acc_req | output | 1 | Access request to the register engine |
| acc_rd | output | 1 | 1 = read access, 0 = write |
| acc_wdata | output | 32 | Register word to write |
| acc_ack | input | 1 | One-cycle access completion |
| acc_rdata | input | 11 | Read word, valid with acc_ack |
| busy | output | 1 | Capture in progress |
| done | output | 1 | One-cycle end-of-capture pulse |
| err | output | 1 | Last capture timed out |
| cap_core | output | 3 | Captured core code |
| cap_band | output | 8 | Captured band |
| cap_bias | output | 4 | Captured bias code |
| lut_idx | input | IDX_W | Table read index |
| lut_hit | output | 1 | Entry at lut_idx holds a capture |
| lut_core | output | 3 | Stored core code |
| lut_band | output | 8 | Stored band |
| lut_bias | output | 4 | Stored bias code |

## Verification
The hardest conditions to reach are the later-run skip rules. Which writes appear depends on what earlier runs wrote, so the bench chains its capture runs in sequence:
- one run changes only the register 2 word;
- another run changes only the register 1 word;
- a third run changes neither.
In each case the full access log is compared with the expected list. The bench drives the calibration line from a countdown that starts when the register 0 write is accepted. This lets a run either keep the block waiting for a known number of cycles or never finish, which forces the timeout path.

// File: rtl/vcap_pkg.sv
package vcap_pkg;
   localparam int BAND_W = 8;
   localparam int CORE_W = 3;
   localparam int BIAS_W = 4;
   localparam int RB_W   = BAND_W + CORE_W;

   // field positions that the synthesizer decodes
   localparam int MUX_LSB  = 27;
   localparam int RSEL_LSB = 26;
   localparam int RBM_LSB  = 12;
   localparam int ACAL_BIT = 21;

   localparam logic [2:0] MUX_READBACK = 3'b111;
   localparam logic [2:0] RSEL_CB      = 3'b001;
   localparam logic [2:0] RSEL_BIAS    = 3'b011;
   localparam logic [2:0] RBM_CALDONE  = 3'b110;
   localparam logic [2:0] RBM_READ     = 3'b111;

   localparam logic [3:0] ADDR_R4  = 4'd4;
   localparam logic [3:0] ADDR_R7  = 4'd7;
   localparam logic [3:0] ADDR_R10 = 4'd10;

   typedef struct packed {
      logic              vld;
      logic [CORE_W-1:0] core;
      logic [BAND_W-1:0] band;
      logic [BIAS_W-1:0] bias;
   } lut_ent_t;

   typedef enum logic [3:0] {
      S_IDLE, S_R10A, S_R7A, S_R4, S_R2, S_R1, S_R0, S_WAIT,
      S_R7B, S_RDCB, S_R10B, S_RDBI, S_FINOK, S_FINERR
   } st_t;

   function automatic logic [31:0] put_field(logic [31:0] base, int lsb,
                                             logic [2:0] val, logic [3:0] addr);
      logic [31:0] w;
      w = base;
      w[lsb +: 3] = val;
      w[3:0] = addr;
      return w;
   endfunction
endpackage

// File: rtl/vcap_timer.sv
module vcap_timer #(
   parameter int TMO_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [TMO_W-1:0] lim,
   output logic             expired
);
   localparam int CW = TMO_W + 1;

   logic [TMO_W-1:0] cnt;

   initial begin
      assert (TMO_W >= 2 && TMO_W <= 32) else $error("vcap_timer: TMO_W out of range");
   end

   assign expired = run && (({1'b0, cnt} + CW'(1)) >= {1'b0, lim});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt <= '0;
      else if (!run)    cnt <= '0;
      else if (!expired) cnt <= cnt + 1'b1;
   end

   // R8
   tmo_cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run && !expired |=> !run || (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/vcap_lut.sv
module vcap_lut
   import vcap_pkg::*;
#(
   parameter int IDX_W  = 4,
   parameter bit RD_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [IDX_W-1:0] widx,
   input  lut_ent_t         wdat,
   input  logic [IDX_W-1:0] ridx,
   output lut_ent_t         rdat
);
   localparam int DEPTH = 1 << IDX_W;

   lut_ent_t mem [DEPTH];

   initial begin
      assert (IDX_W >= 1 && IDX_W <= 10) else $error("vcap_lut: IDX_W out of range");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (we) begin
         mem[widx] <= wdat;
      end
   end

   generate
      if (RD_REG) begin : g_rd_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rdat <= '0;
            else        rdat <= mem[ridx];
         end
      end else begin : g_rd_comb
         assign rdat = mem[ridx];
      end
   endgenerate

   // R6
   lut_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> mem[$past(widx)] == $past(wdat));
endmodule

// File: rtl/vco_cal_capture.sv
module vco_cal_capture
   import vcap_pkg::*;
#(
   parameter int          IDX_W      = 4,
   parameter int          TMO_W      = 16,
   parameter bit          LUT_RD_REG = 1'b0,
   parameter logic [31:0] R4_BASE    = 32'h0,
   parameter logic [31:0] R7_BASE    = 32'h0,
   parameter logic [31:0] R10_BASE   = 32'h0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [IDX_W-1:0]  slot_idx,
   input  logic [31:0]       frq_r0,
   input  logic [31:0]       frq_r1,
   input  logic [31:0]       frq_r2,
   input  logic [TMO_W-1:0]  tmo_lim,
   input  logic              cal_line,
   output logic              acc_req,
   output logic              acc_rd,
   output logic [31:0]       acc_wdata,
   input  logic              acc_ack,
   input  logic [RB_W-1:0]   acc_rdata,
   output logic              busy,
   output logic              done,
   output logic              err,
   output logic [CORE_W-1:0] cap_core,
   output logic [BAND_W-1:0] cap_band,
   output logic [BIAS_W-1:0] cap_bias,
   input  logic [IDX_W-1:0]  lut_idx,
   output logic              lut_hit,
   output logic [CORE_W-1:0] lut_core,
   output logic [BAND_W-1:0] lut_band,
   output logic [BIAS_W-1:0] lut_bias
);
   localparam logic [31:0] W_R10_CB   = put_field(R10_BASE, RSEL_LSB, RSEL_CB, ADDR_R10);
   localparam logic [31:0] W_R10_BIAS = put_field(R10_BASE, RSEL_LSB, RSEL_BIAS, ADDR_R10);
   localparam logic [31:0] W_R7_DONE  = put_field(R7_BASE, RBM_LSB, RBM_CALDONE, ADDR_R7);
   localparam logic [31:0] W_R7_READ  = put_field(R7_BASE, RBM_LSB, RBM_READ, ADDR_R7);
   localparam logic [31:0] W_R4_MUX   = put_field(R4_BASE, MUX_LSB, MUX_READBACK, ADDR_R4);

   st_t              st, st_nx;
   logic [IDX_W-1:0] slot_q;
   logic [31:0]      r0_q, r1_q, r2_q, prev_r1, prev_r2;
   logic             init_q;
   logic [RB_W-1:0]  cb_q;
   logic [BIAS_W-1:0] bias_q;
   logic             need_r4, need_r2, need_r1;
   logic             tmo_exp;
   logic             lut_we;
   lut_ent_t         lut_wd, lut_rd;

   assign need_r4 = !init_q;
   assign need_r2 = !init_q || (r2_q != prev_r2);
   assign need_r1 = !init_q || (r1_q != prev_r1);
   assign busy    = (st != S_IDLE);

   vcap_timer #(.TMO_W(TMO_W)) u_tmo (
      .clk(clk), .rst_n(rst_n), .run(st == S_WAIT), .lim(tmo_lim), .expired(tmo_exp)
   );

   // next state
   always_comb begin
      st_nx = st;
      unique case (st)
         S_IDLE:   if (start) st_nx = S_R10A;
         S_R10A:   if (acc_ack) st_nx = S_R7A;
         S_R7A:    if (acc_ack) st_nx = need_r4 ? S_R4 : need_r2 ? S_R2 : need_r1 ? S_R1 : S_R0;
         S_R4:     if (acc_ack) st_nx = need_r2 ? S_R2 : need_r1 ? S_R1 : S_R0;
         S_R2:     if (acc_ack) st_nx = need_r1 ? S_R1 : S_R0;
         S_R1:     if (acc_ack) st_nx = S_R0;
         S_R0:     if (acc_ack) st_nx = S_WAIT;
         S_WAIT:   if (cal_line) st_nx = S_R7B;
                   else if (tmo_exp) st_nx = S_FINERR;
         S_R7B:    if (acc_ack) st_nx = S_RDCB;
         S_RDCB:   if (acc_ack) st_nx = S_R10B;
         S_R10B:   if (acc_ack) st_nx = S_RDBI;
         S_RDBI:   if (acc_ack) st_nx = S_FINOK;
         S_FINOK:  st_nx = S_IDLE;
         S_FINERR: st_nx = S_IDLE;
         default:  st_nx = S_IDLE;
      endcase
   end

   // access request
   always_comb begin
      acc_req   = 1'b1;
      acc_rd    = 1'b0;
      acc_wdata = '0;
      unique case (st)
         S_R10A: acc_wdata = W_R10_CB;
         S_R7A:  acc_wdata = W_R7_DONE;
         S_R4:   acc_wdata = W_R4_MUX;
         S_R2:   acc_wdata = r2_q;
         S_R1:   acc_wdata = r1_q;
         S_R0: begin
            acc_wdata = r0_q;
            acc_wdata[ACAL_BIT] = 1'b1;
         end
         S_R7B:  acc_wdata = W_R7_READ;
         S_R10B: acc_wdata = W_R10_BIAS;
         S_RDCB, S_RDBI: acc_rd = 1'b1;
         default: acc_req = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= S_IDLE;
         slot_q   <= '0;
         r0_q     <= '0;
         r1_q     <= '0;
         r2_q     <= '0;
         prev_r1  <= '0;
         prev_r2  <= '0;
         init_q   <= 1'b0;
         cb_q     <= '0;
         bias_q   <= '0;
         done     <= 1'b0;
         err      <= 1'b0;
         cap_core <= '0;
         cap_band <= '0;
         cap_bias <= '0;
      end else begin
         st   <= st_nx;
         done <= 1'b0;
         unique case (st)
            S_IDLE: if (start) begin
               slot_q <= slot_idx;
               r0_q   <= frq_r0;
               r1_q   <= frq_r1;
               r2_q   <= frq_r2;
               err    <= 1'b0;
            end
            S_R2:   if (acc_ack) prev_r2 <= r2_q;
            S_R1:   if (acc_ack) prev_r1 <= r1_q;
            S_R0:   if (acc_ack) init_q <= 1'b1;
            S_RDCB: if (acc_ack) cb_q <= acc_rdata;
            S_RDBI: if (acc_ack) bias_q <= acc_rdata[BIAS_W-1:0];
            S_FINOK: begin
               done     <= 1'b1;
               cap_core <= cb_q[BAND_W +: CORE_W];
               cap_band <= cb_q[BAND_W-1:0];
               cap_bias <= bias_q;
            end
            S_FINERR: begin
               done <= 1'b1;
               err  <= 1'b1;
            end
            default: ;
         endcase
      end
   end

   assign lut_we = (st == S_FINOK);
   assign lut_wd = '{vld: 1'b1, core: cb_q[BAND_W +: CORE_W], band: cb_q[BAND_W-1:0], bias: bias_q};

   vcap_lut #(.IDX_W(IDX_W), .RD_REG(LUT_RD_REG)) u_lut (
      .clk(clk), .rst_n(rst_n), .we(lut_we), .widx(slot_q), .wdat(lut_wd),
      .ridx(lut_idx), .rdat(lut_rd)
   );

   assign lut_hit  = lut_rd.vld;
   assign lut_core = lut_rd.core;
   assign lut_band = lut_rd.band;
   assign lut_bias = lut_rd.bias;

   // R2
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc_req && !acc_ack |=> acc_req && $stable(acc_wdata) && $stable(acc_rd));
   // R5
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R8
   err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err) |-> done);
   // R9
   slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy && $past(busy) |-> $stable(slot_q));
endmodule

// File: tb/vco_cal_capture_tb_top.sv
module vco_cal_capture_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int LAT = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [3:0]  slot_idx = '0;
   logic [31:0] frq_r0 = '0, frq_r1 = '0, frq_r2 = '0;
   logic [15:0] tmo_lim = 16'd200;
   logic        cal_line = 1'b0;
   logic        acc_req, acc_rd, acc_ack = 1'b0;
   logic [31:0] acc_wdata;
   logic [10:0] acc_rdata = '0;
   logic        busy, done, err, lut_hit;
   logic [2:0]  cap_core, lut_core;
   logic [7:0]  cap_band, lut_band;
   logic [3:0]  cap_bias, lut_bias;
   logic [3:0]  lut_idx = '0;

   int n_chk = 0, n_bad = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   vco_cal_capture dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .slot_idx(slot_idx),
      .frq_r0(frq_r0), .frq_r1(frq_r1), .frq_r2(frq_r2), .tmo_lim(tmo_lim),
      .cal_line(cal_line), .acc_req(acc_req), .acc_rd(acc_rd), .acc_wdata(acc_wdata),
      .acc_ack(acc_ack), .acc_rdata(acc_rdata), .busy(busy), .done(done), .err(err),
      .cap_core(cap_core), .cap_band(cap_band), .cap_bias(cap_bias),
      .lut_idx(lut_idx), .lut_hit(lut_hit), .lut_core(lut_core),
      .lut_band(lut_band), .lut_bias(lut_bias)
   );

   // register engine model and calibration model
   logic [31:0] log_w [32];
   bit          log_rd [32];
   int          log_cyc [32];
   int          log_n = 0;
   int          cyc = 0, cal_rise = 0, cal_cnt = -1, cal_dly_cfg = -1;
   int          mdl_cnt = 0, rd_n = 0;
   bit          pend_rd = 0;
   logic [10:0] rb_cb_cfg = '0, rb_bi_cfg = '0;

   always @(negedge clk) begin
      cyc++;
      if (cal_cnt > 0) begin
         cal_cnt--;
         if (cal_cnt == 0) begin
            cal_line = 1'b1;
            cal_rise = cyc;
         end
      end
      if (acc_ack) begin
         acc_ack = 1'b0;
      end else if (mdl_cnt > 0) begin
         mdl_cnt--;
         if (mdl_cnt == 0) begin
            acc_ack = 1'b1;
            if (pend_rd) begin
               acc_rdata = (rd_n == 0) ? rb_cb_cfg : rb_bi_cfg;
               rd_n++;
            end
         end
      end else if (acc_req && rst_n) begin
         if (log_n < 32) begin
            log_w[log_n] = acc_wdata;
            log_rd[log_n] = acc_rd;
            log_cyc[log_n] = cyc;
            log_n++;
         end
         pend_rd = acc_rd;
         mdl_cnt = LAT;
         if (!acc_rd && acc_wdata[3:0] == 4'd0) begin
            cal_line = 1'b0;
            cal_cnt = cal_dly_cfg;
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   logic [31:0] exp_w [32];
   bit          exp_rd [32];
   int          exp_n;

   task automatic push_w(input logic [31:0] w);
      exp_w[exp_n] = w; exp_rd[exp_n] = 1'b0; exp_n++;
   endtask
   task automatic push_r();
      exp_w[exp_n] = '0; exp_rd[exp_n] = 1'b1; exp_n++;
   endtask

   task automatic chk_reset();
      @(negedge clk);
      chk(busy == 0 && done == 0 && err == 0 && acc_req == 0, "R1", "idle outputs",
          {28'd0, busy, done, err, acc_req}, 32'd0);
      for (int i = 0; i < 16; i += 5) begin
         lut_idx = 4'(i);
         #1;
         chk(lut_hit == 0, "R1", "empty entry", {31'd0, lut_hit}, 32'd0);
      end
   endtask

   task automatic run_cap(input logic [3:0] slot, input logic [31:0] r0, r1, r2,
                          input int dly, input logic [10:0] cb, bi, input logic [15:0] lim,
                          input bit w4, w2, w1, poke, input string tag);
      int pc_idx;
      bit seen;
      exp_n = 0;
      push_w((32'd1 << 26) | 32'd10);
      push_w((32'd6 << 12) | 32'd7);
      if (w4) push_w((32'd7 << 27) | 32'd4);
      if (w2) push_w(r2);
      if (w1) push_w(r1);
      push_w(r0 | (32'd1 << 21));
      pc_idx = exp_n;
      if (dly >= 0) begin
         push_w((32'd7 << 12) | 32'd7);
         push_r();
         push_w((32'd3 << 26) | 32'd10);
         push_r();
      end
      @(negedge clk);
      log_n = 0; rd_n = 0; cal_dly_cfg = dly;
      rb_cb_cfg = cb; rb_bi_cfg = bi; tmo_lim = lim;
      slot_idx = slot; frq_r0 = r0; frq_r1 = r1; frq_r2 = r2;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (poke) begin
         repeat (5) @(negedge clk);
         slot_idx = 4'd8;
         frq_r2 = 32'hDEAD_0002;
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      seen = 0;
      for (int k = 0; k < 3000 && !seen; k++) begin
         @(negedge clk);
         if (done) seen = 1;
      end
      chk(seen, tag, "done seen", {31'd0, seen}, 32'd1);
      chk(log_n == exp_n, tag, "access count", 32'(log_n), 32'(exp_n));
      for (int i = 0; i < exp_n && i < log_n; i++) begin
         chk(log_rd[i] == exp_rd[i] && (exp_rd[i] || log_w[i] == exp_w[i]),
             (i >= pc_idx) ? "R4" : tag, $sformatf("access %0d", i),
             log_rd[i] ? 32'hFFFF_FFFF : log_w[i], exp_rd[i] ? 32'hFFFF_FFFF : exp_w[i]);
      end
      if (dly >= 0) begin
         if (log_n > pc_idx)
            chk(log_cyc[pc_idx] >= cal_rise, "R3", "request after cal high",
                32'(log_cyc[pc_idx]), 32'(cal_rise));
         chk(err == 0, "R5", "err clear", {31'd0, err}, 32'd0);
         chk(cap_core == cb[10:8] && cap_band == cb[7:0] && cap_bias == bi[3:0], "R5",
             "captured fields", {17'd0, cap_core, cap_band, cap_bias},
             {17'd0, cb[10:8], cb[7:0], bi[3:0]});
         @(negedge clk);
         chk(done == 0, "R5", "done one cycle", {31'd0, done}, 32'd0);
         lut_idx = slot;
         #1;
         chk(lut_hit && lut_core == cb[10:8] && lut_band == cb[7:0] && lut_bias == bi[3:0],
             "R6", "table entry", {16'd0, lut_hit, lut_core, lut_band, lut_bias},
             {16'd0, 1'b1, cb[10:8], cb[7:0], bi[3:0]});
      end else begin
         chk(err == 1, "R8", "err set", {31'd0, err}, 32'd1);
         lut_idx = slot;
         #1;
         chk(lut_hit == 0, "R8", "no table write", {31'd0, lut_hit}, 32'd0);
      end
      if (poke) begin
         lut_idx = 4'd8;
         #1;
         chk(lut_hit == 0, "R9", "ignored start slot", {31'd0, lut_hit}, 32'd0);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk_reset();
      // R2 first run: every write present
      run_cap(4'd3, 32'h0012_3450, 32'h0000_0011, 32'h0000_0022, 20,
              11'h4A7, 11'h7F6, 16'd200, 1, 1, 1, 0, "R2");
      // R7 nothing changed; R5 core D, band 255
      run_cap(4'd5, 32'h0045_6780, 32'h0000_0011, 32'h0000_0022, 8,
              11'h1FF, 11'h00F, 16'd200, 0, 0, 0, 0, "R7");
      // R7 only register 2 word changed; band 0
      run_cap(4'd6, 32'h0000_0100, 32'h0000_0011, 32'h0000_0132, 12,
              11'h200, 11'h003, 16'd200, 0, 1, 0, 0, "R7");
      // R7 only register 1 word changed
      run_cap(4'd1, 32'h0000_0200, 32'h0000_0A51, 32'h0000_0132, 6,
              11'h380, 11'h7F0, 16'd200, 0, 0, 1, 0, "R7");
      // R8 calibration never completes
      run_cap(4'd9, 32'h0000_0300, 32'h0000_0A51, 32'h0000_0132, -1,
              11'h000, 11'h000, 16'd30, 0, 0, 0, 0, "R8");
      lut_idx = 4'd3;
      #1;
      chk(lut_hit && lut_band == 8'hA7, "R8", "earlier entry kept",
          {23'd0, lut_hit, lut_band}, {23'd0, 1'b1, 8'hA7});
      // R9 start while busy ignored; err cleared by new start (R8)
      run_cap(4'd7, 32'h0000_0400, 32'h0000_0A51, 32'h0000_0132, 15,
              11'h455, 11'h009, 16'd200, 0, 0, 0, 1, "R9");
      if (!finished) begin
         finished = 1;
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 200000, 0);
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end
endmodule